// File: doc/BRIEF.md
# Receive-Path Latency-Tolerant Skid Buffer

This block sits on a 64-bit streaming receive path between a packet source and an application consumer. The source does not stop at once when its ready input falls: it may go on presenting beats for up to three more cycles. The buffer keeps every such late beat and offers the stream again to the consumer under a plain valid/ready handshake.

Every beat is stored as one record: the 64-bit data word, start and end markers, an 8-bit byte-enable field, an 8-bit BAR decode field and an error flag. The ready toward the source comes from a register. It is computed from the occupancy, so that it falls while enough free entries remain to absorb the worst-case late beats. With a consumer that never stalls, beats pass through at one per cycle.

Top module: `rx_skid_buffer`

## Requirements
- R1: In the first cycle after a synchronous active-high reset, `up_ready` is 1 and `dn_valid` is 0.
- R2: Beats leave in the order they were accepted, and the sop, eop, BAR decode and error fields of each beat leave with its data.
- R3: `up_ready` is 1 in a cycle exactly when the number of free entries is greater than LATENCY. With the defaults (DEPTH 8, LATENCY 3) and a stalled consumer, a source that sends every cycle gets 5 beats accepted while ready is high.
- R4: A source that keeps `up_valid` high for up to LATENCY cycles after ready falls loses no beat. Occupancy never exceeds DEPTH.
- R5: While `dn_valid` is 1 and `dn_ready` is 0, `dn_valid` stays 1 on the next cycle and every output field stays the same.
- R6: With `dn_ready` held at 1 and one new beat each cycle, the first beat appears one cycle after it is accepted, and later beats follow with no idle cycle.
- R7: The byte-enable field reaches the output bit for bit. Bits [7:4] stay with data [63:32] and bits [3:0] stay with data [31:0].
- R8: A reset while beats are stored drops them. The first beat accepted after the reset is the first beat delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| up_valid | input | 1 | Source offers a beat |
| up_ready | output | 1 | Registered ready toward the source |
| up_data | input | 64 | Beat data |
| up_sop | input | 1 | First beat of a packet |
| up_eop | input | 1 | Last beat of a packet |
| up_be | input | 8 | Byte enables; [7:4] for data [63:32], [3:0] for data [31:0] |
| up_bar | input | 8 | BAR decode field |
| up_err | input | 1 | Error flag |
| dn_valid | output | 1 | Buffered beat available |
| dn_ready | input | 1 | Consumer takes the beat |
| dn_data | output | 64 | Beat data |
| dn_sop | output | 1 | First beat of a packet |
| dn_eop | output | 1 | Last beat of a packet |
| dn_be | output | 8 | Byte enables |
| dn_bar | output | 8 | BAR decode field |
| dn_err | output | 1 | Error flag |

## Verification
The bench combines consumer ready patterns with source valid patterns: both continuous, an alternating consumer, a bursty consumer fed by a continuous source, a sparse source, and a mostly stalled consumer. The continuous case separates a real one-per-cycle path from one that inserts bubbles. The stalled cases push the source into its late-beat window, which shows whether the threshold is placed correctly and whether any entry is overwritten. Each beat's sideband fields come from its sequence number, so a reordered or mismatched field shows up on the beat it belongs to.

// File: rtl/skid_pkg.sv
package skid_pkg;
  localparam int DATA_W = 64;
  localparam int MASK_W = 8;
  localparam int BAR_W  = 8;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              sop;
    logic              eop;
    logic [MASK_W-1:0] be;
    logic [BAR_W-1:0]  bar;
    logic              err;
  } beat_t;

  // Next pointer value, wrapping at the depth.
  function automatic int unsigned ptr_step(int unsigned p, int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

  // Occupancy after one cycle of writes and reads.
  function automatic int unsigned occ_step(int unsigned occ, logic wr, logic rd);
    return occ + (wr ? 1 : 0) - (rd ? 1 : 0);
  endfunction

  // Ready is allowed only while free room exceeds the late-beat window.
  function automatic logic room_ok(int unsigned occ, int unsigned depth, int unsigned lat);
    return (depth - occ) > lat;
  endfunction
endpackage

// File: rtl/skid_store.sv
module skid_store #(
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                  clk,
  input  logic                  wr_en,
  input  logic [PTR_W-1:0]      wr_ptr,
  input  skid_pkg::beat_t       wr_beat,
  input  logic [PTR_W-1:0]      rd_ptr,
  output skid_pkg::beat_t       rd_beat
);
  skid_pkg::beat_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_beat;
  end

  assign rd_beat = mem[rd_ptr];
endmodule

// File: rtl/skid_ptrs.sv
module skid_ptrs #(
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic             rd,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [OCC_W-1:0] occ,
  output logic [OCC_W-1:0] occ_nxt
);
  assign occ_nxt = OCC_W'(skid_pkg::occ_step(32'(occ), wr, rd));

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (wr) wr_ptr <= PTR_W'(skid_pkg::ptr_step(32'(wr_ptr), DEPTH));
      if (rd) rd_ptr <= PTR_W'(skid_pkg::ptr_step(32'(rd_ptr), DEPTH));
      occ <= occ_nxt;
    end
  end
endmodule

// File: rtl/skid_ready_gen.sv
module skid_ready_gen #(
  parameter int DEPTH   = 8,
  parameter int LATENCY = 3,
  localparam int OCC_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OCC_W-1:0] occ_nxt,
  output logic             ready
);
  always_ff @(posedge clk) begin
    if (rst) ready <= 1'b1;
    else     ready <= skid_pkg::room_ok(32'(occ_nxt), DEPTH, LATENCY);
  end
endmodule

// File: rtl/rx_skid_buffer.sv
module rx_skid_buffer #(
  parameter int DEPTH   = 8,
  parameter int LATENCY = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        up_valid,
  output logic        up_ready,
  input  logic [63:0] up_data,
  input  logic        up_sop,
  input  logic        up_eop,
  input  logic [7:0]  up_be,
  input  logic [7:0]  up_bar,
  input  logic        up_err,
  output logic        dn_valid,
  input  logic        dn_ready,
  output logic [63:0] dn_data,
  output logic        dn_sop,
  output logic        dn_eop,
  output logic [7:0]  dn_be,
  output logic [7:0]  dn_bar,
  output logic        dn_err
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OCC_W = $clog2(DEPTH + 1);

  if (DEPTH < LATENCY + 1) begin : g_depth_check
    $error("DEPTH must be at least LATENCY+1");
  end

  skid_pkg::beat_t  in_beat, out_beat;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [OCC_W-1:0] occ, occ_nxt;

  // Named events used by the bound checker.
  logic full;
  logic wr_fire;
  logic rd_fire;

  assign full     = (occ == OCC_W'(DEPTH));
  assign wr_fire  = up_valid && !full;
  assign dn_valid = (occ != '0);
  assign rd_fire  = dn_valid && dn_ready;

  assign in_beat = '{data: up_data, sop: up_sop, eop: up_eop,
                     be: up_be, bar: up_bar, err: up_err};

  skid_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst(rst), .wr(wr_fire), .rd(rd_fire),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .occ(occ), .occ_nxt(occ_nxt)
  );

  skid_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .wr_en(wr_fire), .wr_ptr(wr_ptr), .wr_beat(in_beat),
    .rd_ptr(rd_ptr), .rd_beat(out_beat)
  );

  skid_ready_gen #(.DEPTH(DEPTH), .LATENCY(LATENCY)) u_rdy (
    .clk(clk), .rst(rst), .occ_nxt(occ_nxt), .ready(up_ready)
  );

  assign dn_data = out_beat.data;
  assign dn_sop  = out_beat.sop;
  assign dn_eop  = out_beat.eop;
  assign dn_be   = out_beat.be;
  assign dn_bar  = out_beat.bar;
  assign dn_err  = out_beat.err;
endmodule

// File: rtl/skid_checker.sv
module skid_checker #(
  parameter int DEPTH   = 8,
  parameter int LATENCY = 3,
  localparam int OCC_W  = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             up_valid,
  input logic             up_ready,
  input logic             dn_valid,
  input logic             dn_ready,
  input logic [63:0]      dn_data,
  input logic [7:0]       dn_be,
  input logic [7:0]       dn_bar,
  input logic             dn_sop,
  input logic             dn_eop,
  input logic             dn_err,
  input logic [OCC_W-1:0] occ,
  input logic             wr_fire,
  input logic             rd_fire
);
  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (up_ready && !dn_valid)); // R1

  AST_OCC_TRACK: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (32'(occ) == 32'($past(occ)) + 32'($past(wr_fire)) - 32'($past(rd_fire)))); // R2

  AST_READY_THRESH: assert property (@(posedge clk) disable iff (rst)
    up_ready |-> ((DEPTH - 32'(occ)) > LATENCY)); // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    up_valid |-> (32'(occ) < DEPTH)); // R4

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_data) && $stable(dn_be)
      && $stable(dn_bar) && $stable(dn_sop) && $stable(dn_eop) && $stable(dn_err))); // R5

  AST_NO_BUBBLE: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && dn_ready && up_valid) |=> dn_valid); // R6
endmodule

bind rx_skid_buffer skid_checker #(.DEPTH(DEPTH), .LATENCY(LATENCY)) u_chk (
  .clk(clk), .rst(rst), .up_valid(up_valid), .up_ready(up_ready),
  .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_data(dn_data), .dn_be(dn_be),
  .dn_bar(dn_bar), .dn_sop(dn_sop), .dn_eop(dn_eop), .dn_err(dn_err),
  .occ(occ), .wr_fire(wr_fire), .rd_fire(rd_fire)
);

// File: tb/tb_rx_skid_buffer.sv
`timescale 1ns/100ps
module tb_rx_skid_buffer;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic up_valid = 1'b0, up_ready;
  logic [63:0] up_data = '0;
  logic up_sop = 0, up_eop = 0, up_err = 0;
  logic [7:0] up_be = '0, up_bar = '0;
  logic dn_valid, dn_ready = 1'b0;
  logic [63:0] dn_data;
  logic dn_sop, dn_eop, dn_err;
  logic [7:0] dn_be, dn_bar;

  always #2.5 clk = ~clk;

  rx_skid_buffer dut (
    .clk(clk), .rst(rst), .up_valid(up_valid), .up_ready(up_ready),
    .up_data(up_data), .up_sop(up_sop), .up_eop(up_eop), .up_be(up_be),
    .up_bar(up_bar), .up_err(up_err), .dn_valid(dn_valid), .dn_ready(dn_ready),
    .dn_data(dn_data), .dn_sop(dn_sop), .dn_eop(dn_eop), .dn_be(dn_be),
    .dn_bar(dn_bar), .dn_err(dn_err)
  );

  int tests = 0, fails = 0;
  int q[$];
  int seq = 0, rx_cnt = 0, tx_cnt = 0, hi_cnt = 0, late = 0, cyc = 0;
  int first_rx = -1, last_rx = -1, first_tx = -1;
  logic hold_pending = 0;
  logic [63:0] hold_d;
  logic [7:0] hold_be, hold_bar;
  logic [2:0] hold_flags;

  // Beat contents derived from a sequence number.
  function automatic logic [63:0] f_data(int s); return {16'hC0DE, 16'(s), ~32'(s)}; endfunction
  function automatic logic [7:0] f_be(int s);
    case (s % 4) 0: return 8'hFF; 1: return 8'hF0; 2: return 8'h0F; default: return 8'hC3; endcase
  endfunction
  function automatic logic [7:0] f_bar(int s); return 8'(1 << (s % 8)); endfunction
  function automatic logic f_sop(int s); return (s % 4) == 0; endfunction
  function automatic logic f_eop(int s); return (s % 4) == 3; endfunction
  function automatic logic f_err(int s); return (s % 5) == 0; endfunction

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle: observe at the falling edge, then drive the next inputs.
  task automatic cycle(input logic rdy, input logic want);
    logic ok;
    @(negedge clk);
    cyc++;
    if (hold_pending) begin
      check(dn_valid, "R5 valid held", 64'(dn_valid), 64'd1);
      check(dn_data == hold_d && dn_be == hold_be && dn_bar == hold_bar &&
            {dn_sop, dn_eop, dn_err} == hold_flags, "R5 fields held", dn_data, hold_d);
    end
    dn_ready = rdy;
    if (dn_valid && rdy) begin
      if (q.size() == 0) check(1'b0, "R2 unexpected beat", dn_data, 64'd0);
      else begin
        int s;
        s = q.pop_front();
        check(dn_data == f_data(s), "R2 data order", dn_data, f_data(s));
        check({dn_sop, dn_eop, dn_bar, dn_err} == {f_sop(s), f_eop(s), f_bar(s), f_err(s)},
              "R2 sideband", 64'({dn_sop, dn_eop, dn_bar, dn_err}),
              64'({f_sop(s), f_eop(s), f_bar(s), f_err(s)}));
        check(dn_be[7:4] == f_be(s)[7:4] && dn_be[3:0] == f_be(s)[3:0], "R7 byte lanes",
              64'(dn_be), 64'(f_be(s)));
      end
      rx_cnt++;
      if (first_rx < 0) first_rx = cyc;
      last_rx = cyc;
    end
    hold_pending = dn_valid && !rdy;
    hold_d = dn_data; hold_be = dn_be; hold_bar = dn_bar;
    hold_flags = {dn_sop, dn_eop, dn_err};
    if (up_ready) late = 0; else late++;
    ok = up_ready || (late <= LAT);
    if (want && ok) begin
      up_valid = 1'b1;
      up_data = f_data(seq); up_be = f_be(seq); up_bar = f_bar(seq);
      up_sop = f_sop(seq); up_eop = f_eop(seq); up_err = f_err(seq);
      q.push_back(seq);
      seq++; tx_cnt++;
      if (up_ready) hi_cnt++;
      if (first_tx < 0) first_tx = cyc;
    end else begin
      up_valid = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; up_valid = 1'b0; dn_ready = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    q.delete();
    rx_cnt = 0; tx_cnt = 0; hi_cnt = 0; late = 0; hold_pending = 0;
    first_rx = -1; last_rx = -1; first_tx = -1;
    @(negedge clk);
    check(up_ready == 1'b1, "R1 ready after reset", 64'(up_ready), 64'd1);
    check(dn_valid == 1'b0, "R1 valid after reset", 64'(dn_valid), 64'd0);
  endtask

  typedef struct packed {
    logic [15:0] nb;
    logic [7:0]  rmask;
    logic [7:0]  vmask;
  } scen_t;

  localparam scen_t SCEN [5] = '{
    '{nb: 16'd24, rmask: 8'hFF, vmask: 8'hFF},
    '{nb: 16'd24, rmask: 8'hAA, vmask: 8'hFF},
    '{nb: 16'd30, rmask: 8'h0F, vmask: 8'hFF},
    '{nb: 16'd20, rmask: 8'hFF, vmask: 8'h55},
    '{nb: 16'd32, rmask: 8'h81, vmask: 8'hEE}
  };

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset();

    // Vector table: consumer and source patterns.
    for (int i = 0; i < 5; i++) begin
      do_reset();
      for (int k = 0; k < 2000 && (tx_cnt < int'(SCEN[i].nb) || q.size() != 0); k++)
        cycle(SCEN[i].rmask[k % 8], SCEN[i].vmask[k % 8] && tx_cnt < int'(SCEN[i].nb));
      check(rx_cnt == int'(SCEN[i].nb), "R4 all beats delivered", 64'(rx_cnt), 64'(SCEN[i].nb));
    end

    // R3/R4: stalled consumer, source uses its full late window.
    do_reset();
    for (int k = 0; k < 12; k++) cycle(1'b0, 1'b1);
    check(hi_cnt == 5, "R3 beats accepted while ready high", 64'(hi_cnt), 64'd5);
    check(tx_cnt == 8, "R4 beats including late window", 64'(tx_cnt), 64'd8);
    for (int k = 0; k < 20 && q.size() != 0; k++) cycle(1'b1, 1'b0);
    check(rx_cnt == 8, "R4 stalled beats drained", 64'(rx_cnt), 64'd8);

    // R6: back-to-back throughput.
    do_reset();
    for (int k = 0; k < 20; k++) cycle(1'b1, 1'b1);
    for (int k = 0; k < 10 && q.size() != 0; k++) cycle(1'b1, 1'b0);
    check(first_rx - first_tx == 1, "R6 first beat latency", 64'(first_rx - first_tx), 64'd1);
    check(last_rx - first_rx == 19 && rx_cnt == 20, "R6 no bubbles", 64'(last_rx - first_rx), 64'd19);

    // R8: reset while holding beats.
    do_reset();
    for (int k = 0; k < 3; k++) cycle(1'b0, 1'b1);
    do_reset();
    check(dn_valid == 1'b0, "R8 stored beats dropped", 64'(dn_valid), 64'd0);
    cycle(1'b0, 1'b1);
    for (int k = 0; k < 5; k++) cycle(1'b1, 1'b0);
    check(rx_cnt == 1 && q.size() == 0, "R8 only new beat delivered", 64'(rx_cnt), 64'd1);
    check(dn_valid == 1'b0, "R8 empty after drain", 64'(dn_valid), 64'd0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule